// File: doc/BRIEF.md
# Shared-Line Address/Data Bus Master

This block is a bus master for a bus whose address and data share one set of lines. Each cycle is divided in time. A single address slot comes first, and one or more data slots follow it. The local side asks for a cycle by pulsing a start input. With that pulse it gives a direction, an address and a burst length. The master then runs the whole cycle on its own. It returns each read word with a one-clock valid pulse, asks for each new write word, and signals the end of the cycle with a done pulse.

The shared lines are split the way a tri-state pad would see them: an outgoing value, an output enable and an incoming value. During the address slot the master raises an address strobe for one clock so that slaves can capture the address. Every data slot is closed by a four-phase handshake. The master pulls its active-low data-valid strobe low and waits for the slave's active-low acknowledge. It then releases its strobe and waits for the acknowledge to return high. The acknowledge is asynchronous to the master, so it passes through a two-flop synchronizer. If the slave stays silent for too long, a timeout ends the cycle and sets an error flag.

Top module: `mux_bus_master`

## Requirements
- R1: While reset is asserted and after it is released, the master is idle: `dav_n`=1, `rw_n`=1, `bus_oe`=0, `ale`=0, `busy`=0, `bus_err`=0, `done`=0, `rd_valid`=0.
- R2: `req_start` sampled high in idle causes an address slot in the next clock. In that slot `ale` is 1 for exactly one clock, `bus_oe`=1 and `bus_out` equals the requested address. `dav_n` stays high during the address slot.
- R3: `rw_n` is 1 for a read (`req_rd`=1) and 0 for a write. It holds that value from the address slot until the master returns to idle, and it reads 1 in idle.
- R4: In a read cycle, `bus_oe` is 0 from the clock after the address slot until the cycle ends.
- R5: In a write cycle, each data word is driven with `bus_oe`=1 for one setup clock before `dav_n` falls. It stays unchanged until the strobe is released. `wr_next` is high during that setup clock, which tells the local side to present the following word on `req_wdata`.
- R6: Each data slot is one setup clock and then `dav_n` low. `dav_n` stays low until the synchronized acknowledge is seen low. The next slot's setup begins only after the synchronized acknowledge is seen high again.
- R7: `dac_n` passes through two flops. `dav_n` rises at the third rising edge after `dac_n` is sampled low, and a high `dac_n` ends the release wait at the third edge in the same way.
- R8: In a read, `rd_valid` pulses for one clock per data slot, in the clock after the strobe closes. `rd_data` then holds the `bus_in` value sampled at that edge, so the words come out in slot order.
- R9: `req_len` encodes the burst length as slots minus one (0 to 3 gives 1 to 4 data slots). One cycle has exactly one address slot and `req_len`+1 falling edges of `dav_n`.
- R10: `done` pulses for one clock in the clock after the last slot's release completes, when the master is again idle. No `done` is given on a timeout.
- R11: If a strobe wait or a release wait lasts 64 clocks without progress, the master returns to idle in the next clock with `dav_n`=1 and `bus_oe`=0, and `bus_err` is set. `bus_err` stays set until a new request is accepted. A slave whose synchronized acknowledge first appears in the 64th strobe clock still completes the slot.
- R12: `req_start` is ignored while `busy`=1. It causes no address slot and does not change the running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Request a bus cycle (sampled in idle) |
| req_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| req_addr | input | BUS_W | Address for the address slot |
| req_len | input | LEN_W | Data slots minus one |
| req_wdata | input | BUS_W | Current write word |
| wr_next | output | 1 | Write word taken; present the next one |
| rd_data | output | BUS_W | Last read word |
| rd_valid | output | 1 | One-clock pulse per read word |
| done | output | 1 | One-clock pulse at normal cycle end |
| busy | output | 1 | A cycle is in progress |
| bus_err | output | 1 | Sticky timeout flag |
| bus_out | output | BUS_W | Value driven onto the shared lines |
| bus_oe | output | 1 | Output enable for the shared lines |
| bus_in | input | BUS_W | Value seen on the shared lines |
| ale | output | 1 | Address slot strobe |
| rw_n | output | 1 | Direction: high read, low write |
| dav_n | output | 1 | Active-low data-valid strobe |
| dac_n | input | 1 | Active-low slave acknowledge |

## Verification
The slave model answers both edges of the handshake with programmable delays. Single-slot and four-slot cycles with short and long delays show whether the synchronizer latency and the slot sequencing match on each edge. Reads and writes are mixed so that bus release can be told apart from write-data hold, and slot order is checked against an address-derived pattern. Strobe acknowledges at 61 and 62 clocks of slave delay straddle the timeout boundary. A slave that never acknowledges and one that never releases exercise both wait phases. Start pulses during a running cycle must leave it untouched.

// File: rtl/mbm_pkg.sv
package mbm_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_ADDR    = 3'd1,
    PH_SETUP   = 3'd2,
    PH_STROBE  = 3'd3,
    PH_RELEASE = 3'd4
  } phase_e;

  // phases in which the master waits on the slave's acknowledge
  function automatic logic is_wait(input phase_e p);
    return (p == PH_STROBE) || (p == PH_RELEASE);
  endfunction

  // phases in which the master owns the shared lines
  function automatic logic drives_bus(input phase_e p, input logic rd);
    return (p == PH_ADDR) || (!rd && ((p == PH_SETUP) || (p == PH_STROBE)));
  endfunction

endpackage

// File: rtl/mbm_sync.sv
module mbm_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= RST_VAL;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/mbm_wdog.sv
module mbm_wdog #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);

  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt;

  assign expire = run && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || expire) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  // R11: a wait that is interrupted starts counting again from zero
  p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |=> (!expire));

endmodule

// File: rtl/mbm_slots.sv
module mbm_slots #(
  parameter int MAXB = 4,
  parameter int LW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [LW-1:0] len,
  input  logic          step,
  output logic          last
);

  localparam int SW = $clog2(MAXB + 1);

  logic [SW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  left <= '0;
    else if (load)               left <= SW'(len) + SW'(1);
    else if (step && left != '0) left <= left - 1'b1;
  end

  assign last = (left == SW'(1));

  // R9: a loaded burst holds between one and MAXB slots
  p_left_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ((left >= SW'(1)) && (int'(left) <= MAXB)));

  // R9: a slot is never closed with nothing left to transfer
  p_step_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (left != '0));

endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master
  import mbm_pkg::*;
#(
  parameter int BUS_W       = 16,
  parameter int MAX_BURST   = 4,
  parameter int ACK_LIMIT   = 64,
  parameter int SYNC_STAGES = 2,
  localparam int LEN_W      = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_start,
  input  logic             req_rd,
  input  logic [BUS_W-1:0] req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [BUS_W-1:0] req_wdata,
  output logic             wr_next,
  output logic [BUS_W-1:0] rd_data,
  output logic             rd_valid,
  output logic             done,
  output logic             busy,
  output logic             bus_err,
  output logic [BUS_W-1:0] bus_out,
  output logic             bus_oe,
  input  logic [BUS_W-1:0] bus_in,
  output logic             ale,
  output logic             rw_n,
  output logic             dav_n,
  input  logic             dac_n
);

  phase_e ph, ph_nxt;

  logic             rd_q;
  logic [BUS_W-1:0] addr_q;
  logic [BUS_W-1:0] wd_q;
  logic [BUS_W-1:0] rdat_q;
  logic             rv_q;
  logic             done_q;
  logic             err_q;

  // named internal events
  logic dac_s;
  logic ack_low;
  logic accept;
  logic strobe_closes;
  logic release_closes;
  logic wd_run;
  logic tmo_hit;
  logic slot_last;
  logic take_word;

  mbm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (dac_n),
    .q     (dac_s)
  );

  assign ack_low        = !dac_s;
  assign accept         = (ph == PH_IDLE) && req_start;
  assign strobe_closes  = (ph == PH_STROBE) && ack_low;
  assign release_closes = (ph == PH_RELEASE) && !ack_low;
  assign wd_run         = is_wait(ph) && !strobe_closes && !release_closes;
  assign take_word      = !rd_q && ((ph == PH_ADDR) || (release_closes && !slot_last));

  mbm_wdog #(.LIMIT(ACK_LIMIT)) u_wdog (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (wd_run),
    .expire (tmo_hit)
  );

  mbm_slots #(.MAXB(MAX_BURST), .LW(LEN_W)) u_slots (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .len   (req_len),
    .step  (release_closes),
    .last  (slot_last)
  );

  always_comb begin
    ph_nxt = ph;
    case (ph)
      PH_IDLE:    if (accept) ph_nxt = PH_ADDR;
      PH_ADDR:    ph_nxt = PH_SETUP;
      PH_SETUP:   ph_nxt = PH_STROBE;
      PH_STROBE: begin
        if (tmo_hit)      ph_nxt = PH_IDLE;
        else if (ack_low) ph_nxt = PH_RELEASE;
      end
      PH_RELEASE: begin
        if (tmo_hit)             ph_nxt = PH_IDLE;
        else if (release_closes) ph_nxt = slot_last ? PH_IDLE : PH_SETUP;
      end
      default:    ph_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      rd_q   <= 1'b1;
      addr_q <= '0;
      wd_q   <= '0;
      rdat_q <= '0;
      rv_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      ph     <= ph_nxt;
      rv_q   <= strobe_closes && rd_q;
      done_q <= release_closes && slot_last;
      if (accept) begin
        rd_q   <= req_rd;
        addr_q <= req_addr;
      end
      if (take_word) wd_q <= req_wdata;
      if (strobe_closes && rd_q) rdat_q <= bus_in;
      if (accept)       err_q <= 1'b0;
      else if (tmo_hit) err_q <= 1'b1;
    end
  end

  always_comb begin
    bus_oe = drives_bus(ph, rd_q);
    if (ph == PH_ADDR) bus_out = addr_q;
    else if (bus_oe)   bus_out = wd_q;
    else               bus_out = '0;
  end

  assign ale      = (ph == PH_ADDR);
  assign dav_n    = (ph != PH_STROBE);
  assign rw_n     = (ph == PH_IDLE) ? 1'b1 : rd_q;
  assign wr_next  = (ph == PH_SETUP) && !rd_q;
  assign busy     = (ph != PH_IDLE);
  assign rd_data  = rdat_q;
  assign rd_valid = rv_q;
  assign done     = done_q;
  assign bus_err  = err_q;

  // R2: address strobe lasts one clock and is followed by setup, not a strobe
  p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!ale && dav_n));

  // R12: an address slot only ever follows an idle clock
  p_ale_from_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> $past(!busy));

  // R3: direction is frozen while a cycle runs
  p_rw_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rw_n));

  // R4: a read leaves the shared lines undriven after the address slot
  p_read_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rw_n && !ale) |-> !bus_oe);

  // R5: write data stays driven and unchanged while the strobe is low
  p_wdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dav_n && !rw_n) |-> (bus_oe && $stable(bus_out)));

  // R6: the strobe stays low until the synchronized acknowledge or a timeout
  p_dav_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dav_n && !ack_low && !tmo_hit) |=> !dav_n);

  // R7: a handshake-closed strobe implies dac_n was low three edges earlier
  p_sync_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dav_n) && !$past(tmo_hit)) |-> !$past(dac_n, 3));

  // R8: read words are flagged one clock at a time
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R10: completion is a single pulse seen in idle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !bus_err)) ;

  // R11: a timeout drops everything and flags the error
  p_tmo_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> (!busy && dav_n && !bus_oe && bus_err && !done));

endmodule

// File: tb/mux_bus_master_bench.sv
`timescale 1ns/1ps
module mux_bus_master_bench;

  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_start = 1'b0;
  logic          req_rd = 1'b1;
  logic [W-1:0]  req_addr = '0;
  logic [1:0]    req_len = '0;
  logic [W-1:0]  req_wdata = '0;
  logic          wr_next;
  logic [W-1:0]  rd_data;
  logic          rd_valid;
  logic          done;
  logic          busy;
  logic          bus_err;
  logic [W-1:0]  bus_out;
  logic          bus_oe;
  logic [W-1:0]  bus_in = '0;
  logic          ale;
  logic          rw_n;
  logic          dav_n;
  logic          dac_n = 1'b1;

  mux_bus_master u_mux_bus_master (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_rd(req_rd),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .wr_next(wr_next), .rd_data(rd_data), .rd_valid(rd_valid), .done(done),
    .busy(busy), .bus_err(bus_err), .bus_out(bus_out), .bus_oe(bus_oe),
    .bus_in(bus_in), .ale(ale), .rw_n(rw_n), .dav_n(dav_n), .dac_n(dac_n)
  );

  initial forever #2.5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rdfn(input logic [W-1:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction

  // ---------------- slave model ----------------
  int           lat_lo = 0, lat_hi = 0, s_cnt = 0;
  logic         mute = 1'b0, hold = 1'b0;
  logic [W-1:0] s_addr = '0, s_slot = '0;
  logic [W-1:0] wrote[$];

  initial forever begin
    @(negedge clk);
    if (ale) begin s_addr = bus_out; s_slot = '0; end
    if (!dav_n && dac_n) begin
      if (!mute) begin
        if (s_cnt >= lat_lo) begin
          dac_n = 1'b0; s_cnt = 0;
          if (!rw_n) wrote.push_back(bus_oe ? bus_out : 16'hxxxx);
        end else s_cnt++;
      end
    end else if (dav_n && !dac_n) begin
      if (!hold) begin
        if (s_cnt >= lat_hi) begin dac_n = 1'b1; s_cnt = 0; s_slot = s_slot + 1'b1; end
        else s_cnt++;
      end
    end
    bus_in = rw_n ? rdfn(s_addr + s_slot) : 16'h0000;
  end

  // ---------------- reference model ----------------
  int           m_ph = 0, m_left = 0, m_cnt = 0;
  logic         m_rd = 1'b1, m_err = 1'b0, m_rv = 1'b0, m_done = 1'b0;
  logic         m_s1 = 1'b1, m_s2 = 1'b1, m_ack = 1'b0;
  logic [W-1:0] m_addr = '0, m_wd = '0, m_rdat = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_rd = 1'b1; m_err = 1'b0; m_rv = 1'b0; m_done = 1'b0;
      m_s1 = 1'b1; m_s2 = 1'b1; m_cnt = 0;
    end else begin
      m_ack = !m_s2; m_s2 = m_s1; m_s1 = dac_n;
      m_rv = 1'b0; m_done = 1'b0;
      case (m_ph)
        0: if (req_start) begin
             m_rd = req_rd; m_addr = req_addr; m_left = int'(req_len) + 1;
             m_err = 1'b0; m_ph = 1;
           end
        1: begin if (!m_rd) m_wd = req_wdata; m_ph = 2; end
        2: begin m_ph = 3; m_cnt = 0; end
        3: if (m_ack) begin
             if (m_rd) begin m_rdat = bus_in; m_rv = 1'b1; end
             m_ph = 4; m_cnt = 0;
           end else if (m_cnt == 63) begin m_err = 1'b1; m_ph = 0; end
           else m_cnt++;
        4: if (!m_ack) begin
             m_left--; m_cnt = 0;
             if (m_left == 0) begin m_done = 1'b1; m_ph = 0; end
             else begin m_ph = 2; if (!m_rd) m_wd = req_wdata; end
           end else if (m_cnt == 63) begin m_err = 1'b1; m_ph = 0; end
           else m_cnt++;
        default: m_ph = 0;
      endcase
    end
  end

  // per-clock comparison
  initial forever begin
    @(negedge clk);
    if (!rst_n) begin
      chk("R1", "dav_n in reset", dav_n, 1);
      chk("R1", "rw_n in reset", rw_n, 1);
      chk("R1", "bus_oe in reset", bus_oe, 0);
      chk("R1", "ale/busy/err in reset", {ale, busy, bus_err, done, rd_valid}, 0);
    end else begin
      logic exp_oe;
      exp_oe = (m_ph == 1) || (!m_rd && (m_ph == 2 || m_ph == 3));
      chk("R6", "dav_n", dav_n, m_ph != 3);
      chk("R2", "ale", ale, m_ph == 1);
      chk("R4", "bus_oe", bus_oe, exp_oe);
      if (exp_oe) chk("R5", "bus_out", bus_out, (m_ph == 1) ? m_addr : m_wd);
      chk("R3", "rw_n", rw_n, (m_ph == 0) ? 1'b1 : m_rd);
      chk("R5", "wr_next", wr_next, (m_ph == 2) && !m_rd);
      chk("R12", "busy", busy, m_ph != 0);
      chk("R8", "rd_valid", rd_valid, m_rv);
      if (m_rv) chk("R8", "rd_data", rd_data, m_rdat);
      chk("R10", "done", done, m_done);
      chk("R11", "bus_err", bus_err, m_err);
    end
  end

  // ---------------- event monitor ----------------
  int           ale_cnt = 0, dav_falls = 0, done_cnt = 0;
  logic         prev_dav = 1'b1;
  logic [W-1:0] got[$];

  initial forever begin
    @(negedge clk);
    if (ale) ale_cnt++;
    if (prev_dav && !dav_n) dav_falls++;
    prev_dav = dav_n;
    if (done) done_cnt++;
    if (rd_valid) got.push_back(rd_data);
  end

  // ---------------- stimulus ----------------
  task automatic xfer(input string tag, input logic rd, input logic [W-1:0] a,
                      input logic [1:0] len, input int lo, input int hi,
                      input logic exp_err, input int exp_falls, input logic poke);
    logic [W-1:0] wbuf[4];
    int idx = 0;
    int cyc = 0;
    for (int i = 0; i < 4; i++) wbuf[i] = a + 16'(16'h0111 * (i + 1));
    lat_lo = lo; lat_hi = hi;
    got.delete(); wrote.delete();
    @(negedge clk);
    ale_cnt = 0; dav_falls = 0; done_cnt = 0;
    req_rd = rd; req_addr = a; req_len = len; req_wdata = wbuf[0]; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    while (busy) begin
      @(negedge clk);
      cyc++;
      if (poke) begin
        req_start = (cyc >= 3 && cyc <= 5);
        req_addr  = (cyc >= 3 && cyc <= 5) ? 16'hBEEF : a;
      end
      if (wr_next && idx < 3) begin idx++; req_wdata = wbuf[idx]; end
    end
    req_start = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2", {tag, " address slots"}, ale_cnt, 1);
    chk("R9", {tag, " strobe count"}, dav_falls, exp_falls);
    chk("R10", {tag, " done count"}, done_cnt, exp_err ? 0 : 1);
    chk("R11", {tag, " error flag"}, bus_err, exp_err);
    if (rd) begin
      chk("R8", {tag, " read words"}, got.size(), exp_err ? exp_falls - 1 : exp_falls);
      for (int i = 0; i < got.size(); i++)
        chk("R8", {tag, " read order"}, got[i], rdfn(a + 16'(i)));
    end else begin
      chk("R5", {tag, " write words"}, wrote.size(), exp_falls);
      for (int i = 0; i < wrote.size(); i++)
        chk("R5", {tag, " write value"}, wrote[i], wbuf[i]);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "idle after reset", {busy, dav_n, rw_n, bus_oe}, 4'b0110);

    xfer("R7 single read fast", 1'b1, 16'h1000, 2'd0, 0, 0, 1'b0, 1, 1'b0);
    xfer("single write", 1'b0, 16'h2040, 2'd0, 0, 0, 1'b0, 1, 1'b0);
    xfer("R9 burst4 read", 1'b1, 16'h3300, 2'd3, 3, 2, 1'b0, 4, 1'b0);
    xfer("burst3 write", 1'b0, 16'h44F0, 2'd2, 1, 5, 1'b0, 3, 1'b0);
    xfer("R12 burst2 read poked", 1'b1, 16'h5A5A, 2'd1, 2, 1, 1'b0, 2, 1'b1);
    xfer("burst4 write slow", 1'b0, 16'h0F0F, 2'd3, 7, 4, 1'b0, 4, 1'b0);

    // R11 boundary: latest acknowledge that still closes the slot
    xfer("R11 edge ok", 1'b1, 16'h6000, 2'd0, 61, 0, 1'b0, 1, 1'b0);
    xfer("R11 edge late", 1'b1, 16'h6100, 2'd0, 62, 0, 1'b1, 1, 1'b0);
    repeat (8) @(negedge clk);

    // silent slave: strobe wait expires
    mute = 1'b1;
    xfer("R11 mute", 1'b1, 16'h7000, 2'd1, 0, 0, 1'b1, 1, 1'b0);
    mute = 1'b0;
    chk("R11", "strobe released after timeout", {dav_n, bus_oe, busy}, 3'b100);

    // clears error on the next accepted request
    xfer("R11 recover write", 1'b0, 16'h7100, 2'd0, 0, 0, 1'b0, 1, 1'b0);

    // stuck acknowledge: release wait expires
    hold = 1'b1;
    xfer("R11 hold", 1'b0, 16'h7200, 2'd1, 0, 0, 1'b1, 1, 1'b0);
    hold = 1'b0;
    repeat (10) @(negedge clk);
    xfer("after hold read", 1'b1, 16'h8000, 2'd2, 1, 1, 1'b0, 3, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule